// File: doc/BRIEF.md
# PLL coefficient search engine

This block picks the divider settings for a phase-locked loop. A request for an output frequency and the reference frequency, both in kHz, go in with a start pulse. The engine tries combinations of input divider M, feedback multiplier N and post-divider code, and returns the combination whose output comes closest to the request. It also returns the frequency that combination actually produces.

The request is first limited to the legal output range. The engine then works out which post-divider codes can reach the oscillator range, and tries one candidate per step. Each step uses a shared multi-cycle integer divider. The search ends when every candidate has been tried or when a candidate is judged good enough. A best-fit input selects how strict that early exit is.

The post-divider code is not a monotonic encoding of the ratio. Code 10 divides by 12, which is less than the ratio of code 9.

Top module: `pll_srch`

## Requirements
- R1: After reset, `done_o` is low and `m_o`, `n_o`, `pl_o`, `freq_khz_o` and `inexact_o` are all zero.
- R2: The request is clamped to the range 144000 to 2064000 kHz before use.
  - A request above the range gives the same result as 2064000.
  - A request below the range gives the same result as 144000.
- R3: Post-divider codes 0 to 14 divide by 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24 and 32 respectively. `freq_khz_o` equals floor(ref × N / (M × ratio(`pl_o`))).
- R4: The code window is derived from the VCO target, which is t + floor(t/50), where t is the clamped request.
  - The upper VCO bound is max(2064000, target).
  - The high ratio is the ceiling of upper bound / target.
  - The low ratio is floor(1000000 / target).
  - Both ratios are clamped to 1..32. Each is mapped to the lowest code in 0..13 whose ratio is at least that value, or to 14 if no such code exists.
  - Codes are tried from the low code to the high code inclusive.
- R5: For each code, M is tried in ascending order, and N ascending within each M.
  - For each M, N runs from floor(t × ratio × M / ref) to the ceiling of the same quotient.
  - A candidate replaces the best only when its error is strictly smaller, so the earliest of equal candidates is kept.
  - The initial best is M=255, N=8, code 0, with an error of all ones.
- R6: Let u = floor(ref / M).
  - If u is below 12000, the loop over M ends and the next code is tried.
  - If u is above 38000, that M is skipped.
  - M runs from 1 to 255.
- R7: N outside 8..255 is not used.
  - If the floor value of N exceeds 255, the loop over M ends.
  - A candidate counts only if its VCO, floor(ref × N / M), lies between 1000000 and the upper VCO bound.
  - The candidate's output is floor((vco + floor(ratio/2)) / ratio), and its error is the absolute difference between that output and t.
- R8: A candidate with zero error ends the search immediately, and that candidate is the result.
- R9: With `best_fit_i` low, the search ends at the first new best whose floor(vco / error) exceeds 218.
- R10: `inexact_o` is high exactly when `best_fit_i` was high at start and the final best error is nonzero. This includes the case where no candidate qualified.
- R11: `done_o` pulses high for one cycle when the result outputs update. The outputs hold until the next completed search. `start_i` is sampled only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search; sampled only while idle |
| best_fit_i | input | 1 | 1: search for the closest candidate; 0: accept a result within the ratio threshold |
| ref_khz_i | input | 24 | Reference frequency in kHz |
| req_khz_i | input | 24 | Requested output frequency in kHz |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| m_o | output | 8 | Chosen input divider M |
| n_o | output | 8 | Chosen feedback multiplier N |
| pl_o | output | 4 | Chosen post-divider code |
| freq_khz_o | output | 24 | Frequency achieved by the chosen settings |
| inexact_o | output | 1 | Best-fit search ended with a nonzero error |

## Verification
Replacing the best candidate and ending the search can happen in the same step. The candidate that triggers the stop must itself be committed as the result.

- An exact request (reference 12000, request 1200000) makes the very first in-range candidate both the new best and the stop. The result must show N=100 on code 0.
- A request of 1000500 with best-fit off stops on the second improvement (N=166, code 1). The same request with best-fit on must continue to N=167 and raise the flag.

Every other result is compared with an independent software model of the search, run over several reference frequencies.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int PL_W = 4;
  localparam int RT_W = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_D50, S_DHI, S_DLO, S_MAP, S_PL, S_MU, S_MN,
    S_NCHK, S_VCO, S_OUT, S_CMP, S_FIN
  } srch_st_e;

  // code -> divide ratio; not monotonic above code 9
  function automatic logic [RT_W-1:0] pl_ratio(input logic [PL_W-1:0] c);
    case (c)
      4'd0:  pl_ratio = 7'd1;
      4'd1:  pl_ratio = 7'd2;
      4'd2:  pl_ratio = 7'd3;
      4'd3:  pl_ratio = 7'd4;
      4'd4:  pl_ratio = 7'd5;
      4'd5:  pl_ratio = 7'd6;
      4'd6:  pl_ratio = 7'd8;
      4'd7:  pl_ratio = 7'd10;
      4'd8:  pl_ratio = 7'd12;
      4'd9:  pl_ratio = 7'd16;
      4'd10: pl_ratio = 7'd12;
      4'd11: pl_ratio = 7'd16;
      4'd12: pl_ratio = 7'd20;
      4'd13: pl_ratio = 7'd24;
      default: pl_ratio = 7'd32;
    endcase
  endfunction

  // lowest code in 0..13 reaching ratio r, else 14
  function automatic logic [PL_W-1:0] ratio_to_code(input logic [RT_W-1:0] r);
    ratio_to_code = 4'd14;
    for (int c = 13; c >= 0; c--)
      if (pl_ratio(PL_W'(c)) >= r) ratio_to_code = PL_W'(c);
  endfunction
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int DW = 38
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quot_q, rem_q, den_q, red;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [DW:0]   trial;

  assign trial = {rem_q, quot_q[DW-1]};
  assign red   = trial[DW-1:0] - den_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0; rem_q <= '0; den_q <= '0;
      cnt_q  <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        quot_q <= num_i; rem_q <= '0; den_q <= den_i;
        cnt_q  <= CW'(DW); busy_q <= 1'b1;
      end else if (busy_q) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q  <= red;
          quot_q <= {quot_q[DW-2:0], 1'b1};
        end else begin
          rem_q  <= trial[DW-1:0];
          quot_q <= {quot_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  a_r11_div_done_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r11_div_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/pll_srch_eval.sv
module pll_srch_eval #(
  parameter int DW      = 38,
  parameter int F_W     = 24,
  parameter int VCO_MIN = 1000000,
  parameter int LIM     = 218
) (
  input  logic [DW-1:0]  vco_i,
  input  logic [DW-1:0]  lwv_i,
  input  logic [F_W-1:0] tgt_i,
  input  logic [DW-1:0]  vmax_i,
  input  logic [DW-1:0]  best_err_i,
  input  logic           bf_i,
  output logic [DW-1:0]  err_o,
  output logic           take_o,
  output logic           stop_o
);
  logic          in_rng;
  logic [DW-1:0] tgt_x;
  logic [DW+7:0] scaled;

  assign tgt_x  = DW'(tgt_i);
  assign in_rng = (vco_i >= DW'(VCO_MIN)) && (vco_i <= vmax_i);
  assign err_o  = (lwv_i >= tgt_x) ? lwv_i - tgt_x : tgt_x - lwv_i;
  assign take_o = in_rng && (err_o < best_err_i);
  // floor(vco/err) > LIM  <=>  vco >= (LIM+1)*err, no divide needed
  assign scaled = (DW+8)'(LIM + 1) * {8'b0, err_o};
  assign stop_o = take_o && ((err_o == '0) || (!bf_i && ({8'b0, vco_i} >= scaled)));
endmodule

// File: rtl/pll_srch.sv
module pll_srch
  import pll_srch_pkg::*;
#(
  parameter int F_W     = 24,
  parameter int M_W     = 8,
  parameter int N_W     = 8,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255,
  parameter int DIV_MIN = 1,
  parameter int DIV_MAX = 32,
  parameter int U_MIN   = 12000,
  parameter int U_MAX   = 38000,
  parameter int VCO_MIN = 1000000,
  parameter int VCO_MAX = 2064000,
  parameter int OUT_MIN = 144000,
  parameter int OUT_MAX = 2064000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            best_fit_i,
  input  logic [F_W-1:0]  ref_khz_i,
  input  logic [F_W-1:0]  req_khz_i,
  output logic            done_o,
  output logic [M_W-1:0]  m_o,
  output logic [N_W-1:0]  n_o,
  output logic [PL_W-1:0] pl_o,
  output logic [F_W-1:0]  freq_khz_o,
  output logic            inexact_o
);
  localparam int DW = F_W + ((RT_W + M_W) > N_W ? (RT_W + M_W) : N_W);

  srch_st_e        state;
  logic [F_W-1:0]  ref_q, tgt_q;
  logic            bf_q, pend_q;
  logic [DW-1:0]   vt0_q, vmax_q, vt_q, vco_q, lwv_q, best_err;
  logic [RT_W-1:0] lo_q, hi_q;
  logic [PL_W-1:0] pl_q, pl_lo_q, pl_hi_q, best_pl;
  logic [M_W-1:0]  m_q, best_m;
  logic [N_W:0]    n_q, n2_q;
  logic [N_W-1:0]  best_n;

  logic            div_st, div_go, div_done;
  logic [DW-1:0]   div_num, div_den, div_q, div_r, vt0_nx, err;
  logic [RT_W-1:0] ratio_cur;
  logic            take, stop;

  function automatic logic [RT_W-1:0] clamp_rt(input logic [DW-1:0] v);
    if (v > DW'(DIV_MAX))      clamp_rt = RT_W'(DIV_MAX);
    else if (v < DW'(DIV_MIN)) clamp_rt = RT_W'(DIV_MIN);
    else                       clamp_rt = v[RT_W-1:0];
  endfunction

  assign ratio_cur = pl_ratio(pl_q);
  assign vt0_nx    = DW'(tgt_q) + div_q;
  assign div_st    = state inside {S_D50, S_DHI, S_DLO, S_MU, S_MN, S_VCO, S_OUT, S_FIN};
  assign div_go    = div_st && !pend_q;

  always_comb begin
    div_num = '0;
    div_den = DW'(1);
    case (state)
      S_D50: begin div_num = DW'(tgt_q);          div_den = DW'(50);  end
      S_DHI: begin div_num = vmax_q;              div_den = vt0_q;    end
      S_DLO: begin div_num = DW'(VCO_MIN);        div_den = vt0_q;    end
      S_MU:  begin div_num = DW'(ref_q);          div_den = DW'(m_q); end
      S_MN:  begin div_num = vt_q * DW'(m_q);     div_den = DW'(ref_q); end
      S_VCO: begin div_num = DW'(ref_q) * DW'(n_q); div_den = DW'(m_q); end
      S_OUT: begin div_num = vco_q + DW'(ratio_cur >> 1); div_den = DW'(ratio_cur); end
      S_FIN: begin
        div_num = DW'(ref_q) * DW'(best_n);
        div_den = DW'(best_m) * DW'(pl_ratio(best_pl));
      end
      default: ;
    endcase
  end

  pll_srch_div #(.DW(DW)) i_div (
    .clk_i, .rst_ni, .go_i(div_go), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quot_o(div_q), .rem_o(div_r)
  );

  pll_srch_eval #(.DW(DW), .F_W(F_W), .VCO_MIN(VCO_MIN), .LIM(218)) i_eval (
    .vco_i(vco_q), .lwv_i(lwv_q), .tgt_i(tgt_q), .vmax_i(vmax_q),
    .best_err_i(best_err), .bf_i(bf_q), .err_o(err), .take_o(take), .stop_o(stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; pend_q <= 1'b0;
      ref_q <= '0; tgt_q <= '0; bf_q <= 1'b0;
      vt0_q <= '0; vmax_q <= '0; vt_q <= '0; vco_q <= '0; lwv_q <= '0;
      lo_q <= '0; hi_q <= '0; pl_q <= '0; pl_lo_q <= '0; pl_hi_q <= '0;
      m_q <= '0; n_q <= '0; n2_q <= '0;
      best_m <= '0; best_n <= '0; best_pl <= '0; best_err <= '1;
      done_o <= 1'b0; m_o <= '0; n_o <= '0; pl_o <= '0;
      freq_khz_o <= '0; inexact_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (div_go) pend_q <= 1'b1;
      else if (div_done) pend_q <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          ref_q <= ref_khz_i;
          bf_q  <= best_fit_i;
          if (req_khz_i < F_W'(OUT_MIN))      tgt_q <= F_W'(OUT_MIN);
          else if (req_khz_i > F_W'(OUT_MAX)) tgt_q <= F_W'(OUT_MAX);
          else                                tgt_q <= req_khz_i;
          best_m <= M_W'(M_MAX); best_n <= N_W'(N_MIN);
          best_pl <= '0; best_err <= '1;
          state <= S_D50;
        end
        S_D50: if (div_done) begin
          vt0_q  <= vt0_nx;
          vmax_q <= (vt0_nx > DW'(VCO_MAX)) ? vt0_nx : DW'(VCO_MAX);
          state  <= S_DHI;
        end
        S_DHI: if (div_done) begin
          hi_q  <= clamp_rt(div_q + DW'(div_r != '0));
          state <= S_DLO;
        end
        S_DLO: if (div_done) begin
          lo_q  <= clamp_rt(div_q);
          state <= S_MAP;
        end
        S_MAP: begin
          pl_lo_q <= ratio_to_code(lo_q);
          pl_hi_q <= ratio_to_code(hi_q);
          pl_q    <= ratio_to_code(lo_q);
          state   <= S_PL;
        end
        S_PL: begin
          if (pl_q > pl_hi_q) state <= S_FIN;
          else begin
            vt_q  <= DW'(tgt_q) * DW'(ratio_cur);
            m_q   <= M_W'(M_MIN);
            state <= S_MU;
          end
        end
        S_MU: if (div_done) begin
          if (div_q < DW'(U_MIN)) begin
            pl_q <= pl_q + 1'b1; state <= S_PL;
          end else if (div_q > DW'(U_MAX)) begin
            if (m_q == M_W'(M_MAX)) begin pl_q <= pl_q + 1'b1; state <= S_PL; end
            else m_q <= m_q + 1'b1;
          end else state <= S_MN;
        end
        S_MN: if (div_done) begin
          if (div_q > DW'(N_MAX)) begin
            pl_q <= pl_q + 1'b1; state <= S_PL;
          end else begin
            n_q   <= div_q[N_W:0];
            n2_q  <= div_q[N_W:0] + (N_W+1)'(div_r != '0);
            state <= S_NCHK;
          end
        end
        S_NCHK: begin
          if (n_q > n2_q || n_q > (N_W+1)'(N_MAX)) begin
            if (m_q == M_W'(M_MAX)) begin pl_q <= pl_q + 1'b1; state <= S_PL; end
            else begin m_q <= m_q + 1'b1; state <= S_MU; end
          end else if (n_q < (N_W+1)'(N_MIN)) n_q <= n_q + 1'b1;
          else state <= S_VCO;
        end
        S_VCO: if (div_done) begin vco_q <= div_q; state <= S_OUT; end
        S_OUT: if (div_done) begin lwv_q <= div_q; state <= S_CMP; end
        S_CMP: begin
          if (take) begin
            best_err <= err; best_m <= m_q;
            best_n   <= n_q[N_W-1:0]; best_pl <= pl_q;
          end
          if (stop) state <= S_FIN;
          else begin n_q <= n_q + 1'b1; state <= S_NCHK; end
        end
        S_FIN: if (div_done) begin
          m_o <= best_m; n_o <= best_n; pl_o <= best_pl;
          freq_khz_o <= div_q[F_W-1:0];
          inexact_o  <= bf_q && (best_err != '0);
          done_o     <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_flag_needs_bf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && inexact_o) |-> bf_q);
  a_r4_pl_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {S_MU, S_MN, S_NCHK, S_VCO, S_OUT, S_CMP}) |-> (pl_q >= pl_lo_q && pl_q <= pl_hi_q));
  a_r6_u_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_MN) |-> (DW'(ref_q) >= DW'(U_MIN) * DW'(m_q) && DW'(ref_q) < DW'(U_MAX + 1) * DW'(m_q)));
  a_r7_n_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_CMP && take) |-> (n_q >= (N_W+1)'(N_MIN) && n_q <= (N_W+1)'(N_MAX)));
  a_r5_err_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_CMP && take) |=> (best_err < $past(best_err)));
  a_r8_zero_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_CMP && take && err == '0) |=> (state == S_FIN));
endmodule

// File: tb/test_pll_srch.sv
module test_pll_srch;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, bf = 1'b0;
  logic [23:0] ref_k = '0, req_k = '0;
  logic        done, inexact;
  logic [7:0]  m_out, n_out;
  logic [3:0]  pl_out;
  logic [23:0] freq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pll_srch i_pll_srch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .best_fit_i(bf),
    .ref_khz_i(ref_k), .req_khz_i(req_k), .done_o(done), .m_o(m_out),
    .n_o(n_out), .pl_o(pl_out), .freq_khz_o(freq), .inexact_o(inexact)
  );

  function automatic longint ratio(input longint c);
    case (c)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;   4: return 5;
      5: return 6;   6: return 8;   7: return 10;  8: return 12;  9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24; default: return 32;
    endcase
  endfunction

  function automatic longint code_of(input longint r);
    for (int c = 0; c < 14; c++) if (ratio(c) >= r) return c;
    return 14;
  endfunction

  task automatic model(input longint rf, input longint rq, input bit b,
                       output longint em, output longint en, output longint epl,
                       output longint ef, output bit eflag);
    longint t, vt0, vmax, hi, lo, lc, hc, berr, r, vt, u, n1, n2, vco, lwv, e;
    bit stop = 0;
    t = (rq < 144000) ? 144000 : (rq > 2064000 ? 2064000 : rq);
    vt0 = t + t / 50;
    vmax = (vt0 > 2064000) ? vt0 : 2064000;
    hi = (vmax + vt0 - 1) / vt0; hi = hi > 32 ? 32 : (hi < 1 ? 1 : hi);
    lo = 1000000 / vt0;          lo = lo > 32 ? 32 : (lo < 1 ? 1 : lo);
    lc = code_of(lo); hc = code_of(hi);
    em = 255; en = 8; epl = 0; berr = 64'h7fff_ffff_ffff;
    for (longint pl = lc; pl <= hc && !stop; pl++) begin
      r = ratio(pl); vt = t * r;
      for (longint m = 1; m <= 255 && !stop; m++) begin
        u = rf / m;
        if (u < 12000) break;
        if (u > 38000) continue;
        n1 = vt * m / rf; n2 = (vt * m + rf - 1) / rf;
        if (n1 > 255) break;
        for (longint n = n1; n <= n2 && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;
          if (vco >= 1000000 && vco <= vmax) begin
            lwv = (vco + r / 2) / r;
            e = (lwv > t) ? lwv - t : t - lwv;
            if (e < berr) begin
              berr = e; em = m; en = n; epl = pl;
              if (e == 0 || (!b && vco / e > 218)) stop = 1;
            end
          end
        end
      end
    end
    ef = rf * en / (em * ratio(epl));
    eflag = b && (berr != 0);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input longint rf, input longint rq, input bit b);
    start = 1'b1; ref_k = 24'(rf); req_k = 24'(rq); bf = b;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic run_check(input longint rf, input longint rq, input bit b, input string req);
    longint em, en, epl, ef; bit eflag;
    model(rf, rq, b, em, en, epl, ef, eflag);
    run(rf, rq, b);
    chk(m_out == 8'(em) && n_out == 8'(en), req, "M*256+N", m_out * 256 + n_out, em * 256 + en);
    chk(pl_out == 4'(epl) && freq == 24'(ef), req, "pl code/freq", freq, ef);
    chk(inexact == eflag, req, "inexact", inexact, eflag);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done pulse width", done, 0);
  endtask

  task automatic t_reset();
    chk(done == 0 && inexact == 0, "R1", "done/inexact after reset", done + inexact, 0);
    chk(m_out == 0 && n_out == 0 && pl_out == 0 && freq == 0, "R1", "results after reset",
        m_out + n_out + pl_out + freq, 0);
  endtask

  task automatic t_exact();
    run(12000, 1200000, 1'b1);
    chk(m_out == 1 && n_out == 100 && pl_out == 0, "R8", "exact N", n_out, 100);
    chk(freq == 1200000 && inexact == 0, "R3", "exact freq", freq, 1200000);
    @(negedge clk);
  endtask

  task automatic t_threshold();
    run(12000, 1000500, 1'b0);
    chk(n_out == 166 && pl_out == 1 && m_out == 1, "R9", "early stop N", n_out, 166);
    chk(freq == 996000 && inexact == 0, "R9", "early stop freq", freq, 996000);
    @(negedge clk);
  endtask

  task automatic t_bestfit();
    run(12000, 1000500, 1'b1);
    chk(n_out == 167 && pl_out == 1, "R10", "best fit N", n_out, 167);
    chk(freq == 1002000 && inexact == 1, "R10", "best fit flag", inexact, 1);
    @(negedge clk);
  endtask

  task automatic t_clamp();
    logic [7:0] m0, n0; logic [3:0] p0; logic [23:0] f0;
    run(38000, 2064000, 1'b1); m0 = m_out; n0 = n_out; p0 = pl_out; f0 = freq;
    run(38000, 3000000, 1'b1);
    chk(m_out == m0 && n_out == n0 && pl_out == p0 && freq == f0, "R2", "above range", freq, f0);
    run(38000, 144000, 1'b1); m0 = m_out; n0 = n_out; p0 = pl_out; f0 = freq;
    run(38000, 1000, 1'b1);
    chk(m_out == m0 && n_out == n0 && pl_out == p0 && freq == f0, "R2", "below range", freq, f0);
    @(negedge clk);
  endtask

  task automatic t_scan();
    run_check(38000, 700000, 1'b1, "R5");
    run_check(26000, 333333, 1'b1, "R4");
    run_check(19200, 144000, 1'b0, "R7");
    run_check(38400, 987654, 1'b1, "R6");
    run_check(12000, 2064000, 1'b1, "R3");
  endtask

  task automatic t_no_cand();
    run(10000, 500000, 1'b1);
    chk(m_out == 255 && n_out == 8 && pl_out == 0, "R6", "initial best kept", m_out, 255);
    chk(freq == 313 && inexact == 1, "R10", "no candidate freq", freq, 313);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [23:0] f0 = freq; logic [7:0] n0 = n_out; bit seen = 0;
    ref_k = 24'd26000; req_k = 24'd1500000; bf = 1'b0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (done) seen = 1; end
    chk(!seen && freq == f0 && n_out == n0, "R11", "outputs held without start", freq, f0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_exact();
    t_threshold();
    t_bestfit();
    t_clamp();
    t_scan();
    t_no_cand();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule